// File: doc/BRIEF.md
# Table-Free Byte Substitution Unit (Forward and Inverse)

This block performs the nonlinear byte substitution of the 128-bit block cipher standardised as AES, in either direction, in pure combinational logic with no lookup table. A direction select picks the forward box (used when enciphering) or the inverse box (used when deciphering). The forward direction takes the multiplicative inverse of the input byte in GF(2^8) and then applies the affine transform. The inverse direction applies the inverse affine transform first and then takes the same multiplicative inverse.

The GF(2^8) inverse is not stored anywhere. The byte is carried by a linear isomorphism into the composite field GF((2^4)^2) and inverted there, using a single GF(2^4) inversion plus a few nibble multiplies. A second linear map then brings the result back. One inverter serves both directions: a multiplexer in front of it selects its operand and a multiplexer behind it selects the result. The isomorphism matrices are derived at elaboration time from the field polynomials, so the RTL carries no constant table. The unit suits a narrow datapath that substitutes one byte per cycle, with registers placed by the surrounding pipeline.

Top module: `sbox_cf_sub`

## Requirements
- R1: With `enc_sel`=1, `sub_out` equals A(inv(`sub_in`)). inv is the inverse in GF(2^8) modulo x^8+x^4+x^3+x+1. Bit i of A(v) is v[i]^v[(i+4)%8]^v[(i+5)%8]^v[(i+6)%8]^v[(i+7)%8]^c[i], with c=0x63.
- R2: With `enc_sel`=0, `sub_out` equals inv(A'(`sub_in`)). Bit i of A'(v) is v[(i+2)%8]^v[(i+5)%8]^v[(i+7)%8]^d[i], with d=0x05.
- R3: The inverse of 0x00 is taken to be 0x00, so the forward box maps 0x00 to 0x63 and the inverse box maps 0x63 to 0x00.
- R4: Sample values: forward 0x01→0x7C and 0x53→0xED; inverse 0x7C→0x01 and 0xED→0x53.
- R5: For every byte x, feeding the forward output back through the inverse direction returns x.
- R6: The forward box has no fixed point and no opposite fixed point: for every x, S(x)≠x and S(x)≠~x.
- R7: The output depends only on the present inputs, with no clock or state. A change of `sub_in` or `enc_sel` appears at `sub_out` without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sub_in | input | 8 | Byte to substitute |
| enc_sel | input | 1 | 1 selects the forward box, 0 selects the inverse box |
| sub_out | output | 8 | Substituted byte |

## Verification
Every time the inputs settle, the assertions check the algebra inside the unit. The nibble inverter's result times its operand must equal one. The composite-field inverse must multiply its operand to one and must map zero to zero. The isomorphism pair must return the byte it was given. In the forward direction, undoing the affine step on the output must recover the inverter's result. What only the bench scenarios can show is that the whole mapping matches an independently generated substitution table for all 256 bytes in both directions, together with the known sample values, the round trip, the absence of fixed points and the immediate response to input changes.

// File: rtl/sbox_cf_pkg.sv
package sbox_cf_pkg;

  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam int MAT_W  = BYTE_W * BYTE_W;

  localparam logic [BYTE_W-1:0] FWD_CONST = 8'h63;
  localparam logic [BYTE_W-1:0] INV_CONST = 8'h05;

  // GF(2^8) product, field polynomial x^8+x^4+x^3+x+1
  function automatic logic [BYTE_W-1:0] gf8_mul(input logic [BYTE_W-1:0] a,
                                                input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] acc;
    logic [BYTE_W-1:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[BYTE_W-2:0], 1'b0} ^ (sh[BYTE_W-1] ? 8'h1B : 8'h00);
    end
    return acc;
  endfunction

  // GF(2^4) product, field polynomial x^4+x+1
  function automatic logic [NIB_W-1:0] gf4_mul(input logic [NIB_W-1:0] a,
                                               input logic [NIB_W-1:0] b);
    logic [NIB_W-1:0] acc;
    logic [NIB_W-1:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < NIB_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[NIB_W-2:0], 1'b0} ^ (sh[NIB_W-1] ? 4'h3 : 4'h0);
    end
    return acc;
  endfunction

  // Smallest nibble that makes t^2+t+lambda irreducible over GF(2^4)
  function automatic logic [NIB_W-1:0] find_lambda();
    logic [NIB_W-1:0] res;
    logic found;
    logic has_root;
    res   = '0;
    found = 1'b0;
    for (int lam = 1; lam < 16; lam++) begin
      has_root = 1'b0;
      for (int t = 0; t < 16; t++) begin
        if ((gf4_mul(NIB_W'(t), NIB_W'(t)) ^ NIB_W'(t)) == NIB_W'(lam)) has_root = 1'b1;
      end
      if (!found && !has_root) begin
        res   = NIB_W'(lam);
        found = 1'b1;
      end
    end
    return res;
  endfunction

  localparam logic [NIB_W-1:0] LAMBDA = find_lambda();

  // Root of x^4+x+1 inside GF(2^8): embeds the nibble field
  function automatic logic [BYTE_W-1:0] find_alpha();
    logic [BYTE_W-1:0] res;
    logic [BYTE_W-1:0] v;
    logic found;
    res   = '0;
    found = 1'b0;
    for (int k = 2; k < 256; k++) begin
      v = BYTE_W'(k);
      if (!found && (gf8_mul(gf8_mul(v, v), gf8_mul(v, v)) == (v ^ 8'h01))) begin
        res   = v;
        found = 1'b1;
      end
    end
    return res;
  endfunction

  function automatic logic [BYTE_W-1:0] embed_nib(input logic [NIB_W-1:0] n,
                                                  input logic [BYTE_W-1:0] alpha);
    logic [BYTE_W-1:0] acc;
    logic [BYTE_W-1:0] pw;
    acc = '0;
    pw  = 8'h01;
    for (int i = 0; i < NIB_W; i++) begin
      if (n[i]) acc = acc ^ pw;
      pw = gf8_mul(pw, alpha);
    end
    return acc;
  endfunction

  // Root of y^2+y+lambda inside GF(2^8)
  function automatic logic [BYTE_W-1:0] find_root(input logic [BYTE_W-1:0] alpha);
    logic [BYTE_W-1:0] res;
    logic [BYTE_W-1:0] v;
    logic [BYTE_W-1:0] tgt;
    logic found;
    res   = '0;
    found = 1'b0;
    tgt   = embed_nib(LAMBDA, alpha);
    for (int k = 2; k < 256; k++) begin
      v = BYTE_W'(k);
      if (!found && ((gf8_mul(v, v) ^ v) == tgt)) begin
        res   = v;
        found = 1'b1;
      end
    end
    return res;
  endfunction

  // Apply a column-packed matrix: column k sits at bits [8k +: 8]
  function automatic logic [BYTE_W-1:0] mat_apply(input logic [MAT_W-1:0] m,
                                                  input logic [BYTE_W-1:0] v);
    logic [BYTE_W-1:0] acc;
    acc = '0;
    for (int k = 0; k < BYTE_W; k++) begin
      if (v[k]) acc = acc ^ m[BYTE_W*k +: BYTE_W];
    end
    return acc;
  endfunction

  // Composite {hi,lo} -> standard byte
  function automatic logic [MAT_W-1:0] build_comp_to_std();
    logic [MAT_W-1:0] m;
    logic [BYTE_W-1:0] alpha;
    logic [BYTE_W-1:0] root;
    logic [BYTE_W-1:0] pw;
    alpha = find_alpha();
    root  = find_root(alpha);
    pw    = 8'h01;
    m     = '0;
    for (int k = 0; k < NIB_W; k++) begin
      m[BYTE_W*k +: BYTE_W]           = pw;
      m[BYTE_W*(k+NIB_W) +: BYTE_W]   = gf8_mul(root, pw);
      pw = gf8_mul(pw, alpha);
    end
    return m;
  endfunction

  localparam logic [MAT_W-1:0] COMP_TO_STD = build_comp_to_std();

  // Standard byte -> composite, found as the inverse of the map above
  function automatic logic [MAT_W-1:0] build_std_to_comp();
    logic [MAT_W-1:0] m;
    logic [BYTE_W-1:0] img;
    m = '0;
    for (int c = 0; c < 256; c++) begin
      img = mat_apply(COMP_TO_STD, BYTE_W'(c));
      for (int j = 0; j < BYTE_W; j++) begin
        if (img == (8'h01 << j)) m[BYTE_W*j +: BYTE_W] = BYTE_W'(c);
      end
    end
    return m;
  endfunction

  localparam logic [MAT_W-1:0] STD_TO_COMP = build_std_to_comp();

  // Product in GF((2^4)^2), element = hi*y + lo with y^2 = y + lambda
  function automatic logic [BYTE_W-1:0] cf_mul(input logic [BYTE_W-1:0] a,
                                               input logic [BYTE_W-1:0] b);
    logic [NIB_W-1:0] hh;
    logic [NIB_W-1:0] hi;
    logic [NIB_W-1:0] lo;
    hh = gf4_mul(a[7:4], b[7:4]);
    hi = hh ^ gf4_mul(a[7:4], b[3:0]) ^ gf4_mul(a[3:0], b[7:4]);
    lo = gf4_mul(hh, LAMBDA) ^ gf4_mul(a[3:0], b[3:0]);
    return {hi, lo};
  endfunction

  function automatic logic [BYTE_W-1:0] rotl8(input logic [BYTE_W-1:0] v, input int n);
    return (v << n) | (v >> (BYTE_W - n));
  endfunction

  function automatic logic [BYTE_W-1:0] undo_fwd_affine(input logic [BYTE_W-1:0] v);
    return rotl8(v, 1) ^ rotl8(v, 3) ^ rotl8(v, 6) ^ INV_CONST;
  endfunction

endpackage

// File: rtl/sbox_cf_linmap.sv
module sbox_cf_linmap
  import sbox_cf_pkg::*;
#(
  parameter logic [MAT_W-1:0] MATRIX = STD_TO_COMP
) (
  input  logic [BYTE_W-1:0] map_in,
  output logic [BYTE_W-1:0] map_out
);

  for (genvar j = 0; j < BYTE_W; j++) begin : g_row
    logic [BYTE_W-1:0] terms;
    for (genvar k = 0; k < BYTE_W; k++) begin : g_col
      assign terms[k] = map_in[k] & MATRIX[BYTE_W*k + j];
    end
    assign map_out[j] = ^terms;
  end

endmodule

// File: rtl/sbox_cf_nib_inv.sv
module sbox_cf_nib_inv
  import sbox_cf_pkg::*;
(
  input  logic [NIB_W-1:0] nib_in,
  output logic [NIB_W-1:0] nib_out
);

  logic [NIB_W-1:0] p2, p4, p8, p12;

  // d^-1 = d^14 in GF(2^4); zero maps to zero
  always_comb begin
    p2      = gf4_mul(nib_in, nib_in);
    p4      = gf4_mul(p2, p2);
    p8      = gf4_mul(p4, p4);
    p12     = gf4_mul(p8, p4);
    nib_out = gf4_mul(p12, p2);
  end

  always_comb begin
    if (!$isunknown(nib_in)) begin
      if (nib_in != '0)
        assert_nib_product_R1: assert (gf4_mul(nib_in, nib_out) == 4'h1)
          else $error("nibble inverse product is not one");
      else
        assert_nib_zero_R3: assert (nib_out == '0)
          else $error("nibble inverse of zero is not zero");
    end
  end

endmodule

// File: rtl/sbox_cf_field_inv.sv
module sbox_cf_field_inv
  import sbox_cf_pkg::*;
(
  input  logic [BYTE_W-1:0] cf_in,
  output logic [BYTE_W-1:0] cf_out
);

  logic [NIB_W-1:0] hi, lo, hl_sum, norm, norm_inv;

  assign hi     = cf_in[BYTE_W-1:NIB_W];
  assign lo     = cf_in[NIB_W-1:0];
  assign hl_sum = hi ^ lo;

  // (hi*y+lo)*(hi*y+hi+lo) = hi^2*lambda + hi*lo + lo^2
  always_comb begin
    norm = gf4_mul(gf4_mul(hi, hi), LAMBDA) ^ gf4_mul(hi, lo) ^ gf4_mul(lo, lo);
  end

  sbox_cf_nib_inv u_nib_inv (
    .nib_in  (norm),
    .nib_out (norm_inv)
  );

  always_comb begin
    cf_out = {gf4_mul(hi, norm_inv), gf4_mul(hl_sum, norm_inv)};
  end

  always_comb begin
    if (!$isunknown(cf_in)) begin
      if (cf_in != '0)
        assert_cf_product_R1: assert (cf_mul(cf_in, cf_out) == 8'h01)
          else $error("composite inverse product is not one");
      else
        assert_cf_zero_R3: assert (cf_out == '0)
          else $error("composite inverse of zero is not zero");
    end
  end

endmodule

// File: rtl/sbox_cf_affine.sv
module sbox_cf_affine
  import sbox_cf_pkg::*;
#(
  parameter bit UNDO = 1'b0
) (
  input  logic [BYTE_W-1:0] aff_in,
  output logic [BYTE_W-1:0] aff_out
);

  for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
    if (UNDO) begin : g_undo
      assign aff_out[i] = aff_in[(i+2)%BYTE_W] ^ aff_in[(i+5)%BYTE_W] ^
                          aff_in[(i+7)%BYTE_W] ^ INV_CONST[i];
    end else begin : g_fwd
      assign aff_out[i] = aff_in[i] ^ aff_in[(i+4)%BYTE_W] ^ aff_in[(i+5)%BYTE_W] ^
                          aff_in[(i+6)%BYTE_W] ^ aff_in[(i+7)%BYTE_W] ^ FWD_CONST[i];
    end
  end

endmodule

// File: rtl/sbox_cf_sub.sv
module sbox_cf_sub
  import sbox_cf_pkg::*;
(
  input  logic [7:0] sub_in,
  input  logic       enc_sel,
  output logic [7:0] sub_out
);

  logic [BYTE_W-1:0] pre_aff, inv_operand, cf_operand, cf_result, std_result, post_aff;

  sbox_cf_affine #(.UNDO(1'b1)) u_undo_aff (
    .aff_in  (sub_in),
    .aff_out (pre_aff)
  );

  // shared inverter: operand chosen by direction
  assign inv_operand = enc_sel ? sub_in : pre_aff;

  sbox_cf_linmap #(.MATRIX(STD_TO_COMP)) u_to_cf (
    .map_in  (inv_operand),
    .map_out (cf_operand)
  );

  sbox_cf_field_inv u_field_inv (
    .cf_in  (cf_operand),
    .cf_out (cf_result)
  );

  sbox_cf_linmap #(.MATRIX(COMP_TO_STD)) u_to_std (
    .map_in  (cf_result),
    .map_out (std_result)
  );

  sbox_cf_affine #(.UNDO(1'b0)) u_fwd_aff (
    .aff_in  (std_result),
    .aff_out (post_aff)
  );

  assign sub_out = enc_sel ? post_aff : std_result;

  always_comb begin
    if (!$isunknown({sub_in, enc_sel})) begin
      assert_iso_roundtrip_R5: assert (mat_apply(COMP_TO_STD, cf_operand) == inv_operand)
        else $error("isomorphism pair does not return its input");
      assert_inv_nonzero_R3: assert ((std_result == '0) == (inv_operand == '0))
        else $error("inverse zero mapping broken");
      if (enc_sel)
        assert_fwd_affine_R1: assert (undo_fwd_affine(sub_out) == std_result)
          else $error("forward output does not undo to the inverse");
      else
        assert_inv_path_R2: assert (gf8_mul(sub_out, pre_aff) == ((pre_aff == '0) ? 8'h00 : 8'h01))
          else $error("inverse-direction output is not the field inverse");
    end
  end

endmodule

// File: tb/sbox_cf_sub_bench.sv
module sbox_cf_sub_bench;

  logic       clk;
  logic [7:0] sub_in;
  logic       enc_sel;
  logic [7:0] sub_out;

  int checks;
  int errors;
  logic [7:0] inv_ref [256];
  logic [7:0] fwd_ref [256];
  logic [7:0] bwd_ref [256];

  sbox_cf_sub u_sbox_cf_sub (
    .sub_in  (sub_in),
    .enc_sel (enc_sel),
    .sub_out (sub_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 8'h00;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
    end
    return p;
  endfunction

  function automatic logic [7:0] ref_aff(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      r[i] = v[i] ^ v[(i+4)%8] ^ v[(i+5)%8] ^ v[(i+6)%8] ^ v[(i+7)%8];
    return r ^ 8'h63;
  endfunction

  function automatic logic [7:0] ref_unaff(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      r[i] = v[(i+2)%8] ^ v[(i+5)%8] ^ v[(i+7)%8];
    return r ^ 8'h05;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp,
                       input logic [7:0] stim);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s in=%02h actual=%02h expected=%02h", req, stim, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] v, input logic dir);
    sub_in  = v;
    enc_sel = dir;
    #1;
  endtask

  task automatic build_refs();
    for (int x = 0; x < 256; x++) begin
      inv_ref[x] = 8'h00;
      for (int y = 1; y < 256; y++)
        if (ref_mul(8'(x), 8'(y)) == 8'h01) inv_ref[x] = 8'(y);
    end
    for (int x = 0; x < 256; x++) begin
      fwd_ref[x] = ref_aff(inv_ref[x]);
      bwd_ref[x] = inv_ref[ref_unaff(8'(x))];
    end
  endtask

  task automatic t_start_state();
    apply(8'h00, 1'b1);
    check("R3 S(00)", sub_out, 8'h63, 8'h00);
    apply(8'h63, 1'b0);
    check("R3 InvS(63)", sub_out, 8'h00, 8'h63);
  endtask

  task automatic t_known_values();
    apply(8'h01, 1'b1); check("R4 S(01)", sub_out, 8'h7C, 8'h01);
    apply(8'h53, 1'b1); check("R4 S(53)", sub_out, 8'hED, 8'h53);
    apply(8'h7C, 1'b0); check("R4 InvS(7C)", sub_out, 8'h01, 8'h7C);
    apply(8'hED, 1'b0); check("R4 InvS(ED)", sub_out, 8'h53, 8'hED);
  endtask

  task automatic t_forward_all();
    for (int x = 0; x < 256; x++) begin
      apply(8'(x), 1'b1);
      check("R1 forward", sub_out, fwd_ref[x], 8'(x));
    end
  endtask

  task automatic t_inverse_all();
    for (int x = 0; x < 256; x++) begin
      apply(8'(x), 1'b0);
      check("R2 inverse", sub_out, bwd_ref[x], 8'(x));
    end
  endtask

  task automatic t_round_trip();
    logic [7:0] mid;
    for (int x = 0; x < 256; x++) begin
      apply(8'(x), 1'b1);
      mid = sub_out;
      apply(mid, 1'b0);
      check("R5 round trip", sub_out, 8'(x), 8'(x));
    end
  endtask

  task automatic t_no_fixed();
    for (int x = 0; x < 256; x++) begin
      apply(8'(x), 1'b1);
      checks++;
      if (sub_out === 8'(x) || sub_out === ~8'(x)) begin
        errors++;
        $display("FAIL R6 in=%02h actual=%02h expected=neither %02h nor %02h",
                 8'(x), sub_out, 8'(x), ~8'(x));
      end
    end
  endtask

  task automatic t_no_clock();
    @(negedge clk);
    sub_in = 8'hA5; enc_sel = 1'b1;
    #0.5;
    check("R7 immediate fwd", sub_out, fwd_ref[8'hA5], 8'hA5);
    enc_sel = 1'b0;
    #0.5;
    check("R7 immediate dir switch", sub_out, bwd_ref[8'hA5], 8'hA5);
    sub_in = 8'h3C;
    #0.5;
    check("R7 immediate data change", sub_out, bwd_ref[8'h3C], 8'h3C);
  endtask

  initial begin
    checks  = 0;
    errors  = 0;
    sub_in  = 8'h00;
    enc_sel = 1'b1;
    build_refs();
    @(negedge clk);
    t_start_state();
    t_known_values();
    t_forward_all();
    t_inverse_all();
    t_round_trip();
    t_no_fixed();
    t_no_clock();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule